// File: doc/BRIEF.md
# Trace Word Slot Unpacker

This block sits behind the read port of a trace capture memory. Each 32-bit word taken from that memory carries the results of one, two or three core cycles, packed as fixed-width slots. The block accepts the words on a valid/ready stream and emits one record per packed cycle on a second valid/ready stream. Each record holds a 3-bit pipeline status, a 16-bit packet field, a sync flag and a trigger flag.

A two-bit width code, captured together with each word, sets the slot layout. Packets of 4 bits give three slots per word. Packets of 8 bits give two. Packets of 16 bits give one. When a slot's status equals the trigger code, the emitted status is taken from the low three packet bits instead, and the trigger flag is raised. Slots are emitted lowest offset first. A new word is taken only once every slot of the held word has been handed on. The block does not decode the trace protocol beyond the pipeline status.

Top module: `trace_slot_unpacker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: Width code 2'b00 selects 4-bit packets. Three 8-bit slots start at word bits 0, 8 and 16. In each slot, bits [2:0] are the status, bits [6:3] the packet and bit 7 the sync flag. Word bits [31:24] have no effect.
- R3: Width code 2'b01 selects 8-bit packets. Two 12-bit slots start at word bits 0 and 12. In each slot, bits [2:0] are the status, bits [10:3] the packet and bit 11 the sync flag. Word bits [31:24] have no effect.
- R4: Width codes 2'b10 and 2'b11 both select 16-bit packets. One slot holds the status in bits [2:0], the packet in bits [18:3] and the sync flag in bit 19. Word bits [31:20] have no effect.
- R5: When a slot's status equals the parameter TRIG_CODE (default 3'b110), out_status equals packet bits [2:0] and out_trig is 1. For any other status, out_status is the slot status and out_trig is 0.
- R6: out_packet is 16 bits wide. In the 4-bit and 8-bit modes the packet is zero-extended, so the bits above the packet are 0.
- R7: Each accepted word yields exactly 3, 2 or 1 records for the 4-bit, 8-bit and 16-bit modes, in order of increasing slot offset, and no record is emitted without an accepted word.
- R8: in_ready is 0 from the cycle after a word is accepted until the last record of that word has been accepted. It returns to 1 in the next cycle.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and all record outputs stay unchanged in the next cycle.
- R10: The width code is sampled with the word. A change of in_width while that word is being emitted has no effect on its records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken |
| in_word | input | 32 | Packed trace word |
| in_width | input | 2 | Packet width code (00 4-bit, 01 8-bit, 10/11 16-bit) |
| out_valid | output | 1 | Record offered |
| out_ready | input | 1 | Record taken by consumer |
| out_status | output | 3 | Pipeline status, substituted on trigger cycles |
| out_packet | output | 16 | Packet field, zero-extended |
| out_sync | output | 1 | Sync flag of the slot |
| out_trig | output | 1 | Slot carried the trigger code |

## Verification
The bench goes after the slot boundaries in every mode. It puts each of the eight status codes in every slot position, and it drives random upper bits that must be ignored. A wrong offset or field width in any mode shows up as shifted packets or misplaced sync flags. A missing or misplaced substitution shows up as a raw trigger code on out_status, or as a trigger flag with the wrong status. The bench applies irregular backpressure, and it changes in_width as soon as a word has been taken. A design that drops or repeats a slot during a stall, lets its record change while stalled, takes a second word early, or follows the live width code produces records that do not match the expected sequence.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int WORD_W     = 32;
    localparam int STAT_W     = 3;
    localparam int PKT_W      = 16;
    localparam int SYNC_W     = 1;
    localparam int NUM_MODES  = 3;
    localparam int SLOT_IDX_W = 2;

    typedef enum logic [1:0] {
        PW_NIBBLE = 2'b00,
        PW_BYTE   = 2'b01,
        PW_HALF   = 2'b10,
        PW_HALF_B = 2'b11
    } port_width_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [PKT_W-1:0]  packet;
        logic              sync;
        logic              trig;
    } trace_rec_t;

    // Packet width in bits for layout index m (0 nibble, 1 byte, 2 half)
    function automatic int pkt_bits(int m);
        case (m)
            0:       return 4;
            1:       return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int slot_bits(int m);
        return STAT_W + pkt_bits(m) + SYNC_W;
    endfunction

    function automatic int slots_per_word(int m);
        case (m)
            0:       return 3;
            1:       return 2;
            default: return 1;
        endcase
    endfunction

    // Layout index for a width code; both upper codes share the half layout
    function automatic int layout_of(port_width_e pw);
        case (pw)
            PW_NIBBLE: return 0;
            PW_BYTE:   return 1;
            default:   return 2;
        endcase
    endfunction

    function automatic logic [SLOT_IDX_W-1:0] last_slot(port_width_e pw);
        return SLOT_IDX_W'(slots_per_word(layout_of(pw)) - 1);
    endfunction

    // Highest word bit any layout reaches
    function automatic int used_word_bits();
        int best;
        best = 0;
        for (int m = 0; m < NUM_MODES; m++) begin
            if (slots_per_word(m) * slot_bits(m) > best)
                best = slots_per_word(m) * slot_bits(m);
        end
        return best;
    endfunction

    localparam int USED_W = used_word_bits();

endpackage

// File: rtl/tsu_word_hold.sv
module tsu_word_hold
    import tsu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [USED_W-1:0]     in_bits,
    input  port_width_e           in_mode,
    output logic                  in_ready,
    input  logic                  rec_taken,
    output logic                  busy,
    output logic [USED_W-1:0]     held_bits,
    output port_width_e           held_mode,
    output logic [SLOT_IDX_W-1:0] slot_idx
);

    logic at_last;

    assign at_last  = (slot_idx == last_slot(held_mode));
    assign in_ready = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            held_bits <= '0;
            held_mode <= PW_NIBBLE;
            slot_idx  <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                busy      <= 1'b1;
                held_bits <= in_bits;
                held_mode <= in_mode;
                slot_idx  <= '0;
            end
        end else if (rec_taken) begin
            if (at_last) begin
                busy     <= 1'b0;
                slot_idx <= '0;
            end else begin
                slot_idx <= slot_idx + 1'b1;
            end
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> slot_idx <= last_slot(held_mode)); // R7

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(held_mode) && $stable(held_bits)); // R10

    AST_FIRST_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> slot_idx == '0); // R7

endmodule

// File: rtl/tsu_slot_extract.sv
module tsu_slot_extract
    import tsu_pkg::*;
(
    input  logic [USED_W-1:0]     word,
    input  port_width_e           mode,
    input  logic [SLOT_IDX_W-1:0] idx,
    output trace_rec_t            raw
);

    trace_rec_t cand_by_layout [NUM_MODES];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_layout
        localparam int PB = pkt_bits(m);
        localparam int SB = slot_bits(m);
        localparam int NS = slots_per_word(m);

        trace_rec_t slot_rec [NS];
        trace_rec_t cand;

        for (genvar s = 0; s < NS; s++) begin : g_slot
            localparam int OFS = s * SB;
            assign slot_rec[s] = '{
                status: word[OFS +: STAT_W],
                packet: PKT_W'(word[OFS + STAT_W +: PB]),
                sync:   word[OFS + STAT_W + PB],
                trig:   1'b0
            };
        end

        always_comb begin
            cand = '0;
            for (int k = 0; k < NS; k++) begin
                if (idx == SLOT_IDX_W'(k))
                    cand = slot_rec[k];
            end
        end

        assign cand_by_layout[m] = cand;
    end

    always_comb begin
        case (mode)
            PW_NIBBLE: raw = cand_by_layout[0];
            PW_BYTE:   raw = cand_by_layout[1];
            default:   raw = cand_by_layout[2];
        endcase
    end

endmodule

// File: rtl/tsu_trig_subst.sv
module tsu_trig_subst
    import tsu_pkg::*;
#(
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  trace_rec_t raw,
    output trace_rec_t rec
);

    logic hit;

    assign hit = (raw.status == TRIG_CODE);

    always_comb begin
        rec      = raw;
        rec.trig = hit;
        if (hit)
            rec.status = raw.packet[STAT_W-1:0];
    end

endmodule

// File: rtl/trace_slot_unpacker.sv
module trace_slot_unpacker
    import tsu_pkg::*;
#(
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [1:0]        in_width,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [STAT_W-1:0] out_status,
    output logic [PKT_W-1:0]  out_packet,
    output logic              out_sync,
    output logic              out_trig
);

    logic                  busy;
    logic [USED_W-1:0]     held_bits;
    port_width_e           held_mode;
    logic [SLOT_IDX_W-1:0] slot_idx;
    trace_rec_t            raw_rec;
    trace_rec_t            final_rec;
    logic                  rec_taken;
    logic                  unused_upper_bits;

    assign unused_upper_bits = ^in_word[WORD_W-1:USED_W];
    assign rec_taken         = busy && out_ready;

    tsu_word_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bits   (in_word[USED_W-1:0]),
        .in_mode   (port_width_e'(in_width)),
        .in_ready  (in_ready),
        .rec_taken (rec_taken),
        .busy      (busy),
        .held_bits (held_bits),
        .held_mode (held_mode),
        .slot_idx  (slot_idx)
    );

    tsu_slot_extract u_extract (
        .word (held_bits),
        .mode (held_mode),
        .idx  (slot_idx),
        .raw  (raw_rec)
    );

    tsu_trig_subst #(.TRIG_CODE(TRIG_CODE)) u_subst (
        .raw (raw_rec),
        .rec (final_rec)
    );

    assign out_valid  = busy;
    assign out_status = final_rec.status;
    assign out_packet = final_rec.packet;
    assign out_sync   = final_rec.sync;
    assign out_trig   = final_rec.trig;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && in_ready); // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_status)
            && $stable(out_packet) && $stable(out_sync) && $stable(out_trig)); // R9

    AST_TRIG_STATUS_FROM_PACKET: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_trig |-> out_status == out_packet[STAT_W-1:0]); // R5

    AST_NIBBLE_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
        out_valid && held_mode == PW_NIBBLE |-> out_packet[PKT_W-1:4] == '0); // R6

    AST_BYTE_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
        out_valid && held_mode == PW_BYTE |-> out_packet[PKT_W-1:8] == '0); // R6

    AST_NO_TAKE_WHILE_DRAINING: assert property (@(posedge clk) disable iff (rst)
        out_valid && !(out_ready && slot_idx == last_slot(held_mode)) |=> !in_ready); // R8

endmodule

// File: tb/test_trace_slot_unpacker.sv
module test_trace_slot_unpacker;

    localparam int CLK_PERIOD = 10;
    localparam int SWEEP      = 256;

    typedef struct {
        int status;
        int packet;
        int sync;
        int trig;
        int mode;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [1:0]  in_width = 2'b00;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_status;
    logic [15:0] out_packet;
    logic        out_sync;
    logic        out_trig;

    int checks = 0;
    int errors = 0;
    int bp_kind = 0;
    int cyc = 0;
    int total_exp = 0;
    int total_got = 0;
    bit finished = 1'b0;

    exp_t q[$];

    bit          stall_prev = 1'b0;
    logic [2:0]  sv_status;
    logic [15:0] sv_packet;
    logic        sv_sync;
    logic        sv_trig;

    trace_slot_unpacker i_trace_slot_unpacker (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .in_width   (in_width),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_status (out_status),
        .out_packet (out_packet),
        .out_sync   (out_sync),
        .out_trig   (out_trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int n_slots(int m);
        return (m == 0) ? 3 : (m == 1) ? 2 : 1;
    endfunction

    function automatic int p_bits(int m);
        return (m == 0) ? 4 : (m == 1) ? 8 : 16;
    endfunction

    function automatic exp_t model(logic [31:0] w, int m, int s);
        exp_t r;
        longint unsigned f;
        int pb;
        pb = p_bits(m);
        f = longint'(w) >> (s * (pb + 4));
        r.status = int'(f % 8);
        r.packet = int'((f / 8) % (longint'(1) << pb));
        r.sync   = int'((f >> (3 + pb)) % 2);
        r.trig   = 0;
        r.mode   = m;
        if (r.status == 6) begin
            r.status = r.packet % 8;
            r.trig   = 1;
        end
        return r;
    endfunction

    // Word whose every slot carries status c, a packet pattern and sync
    function automatic logic [31:0] build_word(int m, int c, int pk, int sy, logic [31:0] hi);
        logic [31:0] w;
        int pb;
        pb = p_bits(m);
        w = hi;
        for (int s = 0; s < n_slots(m); s++) begin
            longint unsigned field;
            field = longint'(c) + (longint'((pk + s) % (1 << pb)) << 3)
                  + (longint'(sy) << (3 + pb));
            w = w & ~(32'((longint'(1) << (pb + 4)) - 1) << (s * (pb + 4)));
            w = w | (32'(field) << (s * (pb + 4)));
        end
        return w;
    endfunction

    function automatic logic [31:0] hash(int i);
        return 32'(i) * 32'h9E37_79B9 ^ (32'(i) << 13) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic note(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic send(logic [31:0] w, int m);
        @(negedge clk);
        in_word  = w;
        in_width = 2'(m);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_width = 2'(m + 1);
        in_word  = ~w;
        for (int s = 0; s < n_slots(m); s++) begin
            q.push_back(model(w, m, s));
        end
        total_exp += n_slots(m);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (bp_kind)
                0:       out_ready = 1'b1;
                1:       out_ready = ((cyc * 7 + 3) % 5) != 0;
                default: out_ready = ((cyc * 3) % 7) < 3;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (stall_prev) begin
                note(out_valid && out_status == sv_status && out_packet == sv_packet
                     && out_sync == sv_sync && out_trig == sv_trig,
                     "R9", "record changed during stall",
                     {out_valid, out_status, out_packet, out_sync, out_trig},
                     {1'b1, sv_status, sv_packet, sv_sync, sv_trig});
            end
            if (q.size() > 0) begin
                note(!in_ready, "R8", "in_ready while slots pending", int'(in_ready), 0);
            end else begin
                note(in_ready, "R8", "in_ready when idle", int'(in_ready), 1);
                note(!out_valid, "R7", "record without word", int'(out_valid), 0);
            end
            if (out_valid && out_ready && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total_got++;
                if (e.trig != 0)
                    note(int'(out_status) == e.status && int'(out_trig) == 1,
                         "R5", "trigger substitution",
                         {out_status, out_trig}, e.status * 2 + 1);
                else
                    note(int'(out_status) == e.status && int'(out_trig) == 0,
                         "R5", "status pass-through",
                         {out_status, out_trig}, e.status * 2);
                if (e.mode == 0)
                    note(int'(out_packet) == e.packet && int'(out_sync) == e.sync,
                         "R2", "nibble slot packet/sync (R10 width held)",
                         {out_packet, out_sync}, e.packet * 2 + e.sync);
                else if (e.mode == 1)
                    note(int'(out_packet) == e.packet && int'(out_sync) == e.sync,
                         "R3", "byte slot packet/sync (R10 width held)",
                         {out_packet, out_sync}, e.packet * 2 + e.sync);
                else
                    note(int'(out_packet) == e.packet && int'(out_sync) == e.sync,
                         "R4", "half slot packet/sync (R10 width held)",
                         {out_packet, out_sync}, e.packet * 2 + e.sync);
                if (e.mode < 2)
                    note((int'(out_packet) >> p_bits(e.mode)) == 0,
                         "R6", "packet zero extension", int'(out_packet), e.packet);
            end
            stall_prev = out_valid && !out_ready;
            sv_status  = out_status;
            sv_packet  = out_packet;
            sv_sync    = out_sync;
            sv_trig    = out_trig;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", total_got, total_exp);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        note(!out_valid && in_ready, "R1", "state during reset",
             {out_valid, in_ready}, 1);
        rst = 1'b0;
        @(negedge clk);
        note(!out_valid && in_ready, "R1", "state after reset",
             {out_valid, in_ready}, 1);

        for (int bp = 0; bp < 3; bp++) begin
            bp_kind = bp;
            for (int m = 0; m < 4; m++) begin
                // every status code in every slot, with sync both ways
                for (int c = 0; c < 8; c++) begin
                    for (int sy = 0; sy < 2; sy++) begin
                        send(build_word(m, c, c * 37 + sy * 11 + 5, sy, hash(c + 16 * sy)), m);
                    end
                end
                send(32'h0000_0000, m);
                send(32'hFFFF_FFFF, m);
                for (int i = 0; i < SWEEP / (bp + 1); i++) begin
                    send(hash(i + 1000 * m), m);
                    if (i % 5 == 0) repeat (i % 3) @(negedge clk);
                end
            end
        end

        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        note(total_got == total_exp, "R7", "record count per word sum", total_got, total_exp);
        note(in_ready && !out_valid, "R8", "idle at end", {in_ready, out_valid}, 2);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule